// File: doc/BRIEF.md
# Retransmit-Capable FIFO Buffer

This block is a first-in/first-out store, nine bits wide by default, whose depth is a power of two from 512 to 4096 words. Writers and readers use active-low strobes that are sampled on the rising clock edge. Three active-low status outputs report when the store is empty, when it is full, and when it is more than half occupied. Read data is registered: the word for an accepted read appears, with a data-valid pulse, in the cycle after the strobe is sampled.

An active-low rewind input sends the read side back to the first word stored since reset. The write side is left alone. This lets a consumer replay a block of data that is shorter than the store, without the producer writing it again. Occupancy and all flags are then recomputed from the new pointer distance. The external reset is asserted asynchronously and released through a two-stage synchroniser.

Top module: `retx_fifo`

## Requirements
- R1: While reset is asserted, and after it has been released with no strobes, empty_n is 0, full_n is 1, half_n is 1 and dvalid is 0.
- R2: Words are read out in the order they were accepted. For a read accepted at edge k, dout carries the word after edge k and dvalid is 1 until edge k+1.
- R3: A write strobe while full_n is 0 is ignored. No word is stored, the write position does not move, and later reads return only the earlier words.
- R4: A read strobe while empty_n is 0 is ignored. dvalid stays 0 and the read position does not move.
- R5: With no reads since reset, full_n goes to 0 right after the DEPTH-th accepted write and not earlier.
- R6: empty_n is 0 exactly when the stored word count is zero.
- R7: When a read and a write are both accepted at the same edge, both happen and the count is unchanged. A read strobe at an empty store never returns the word written at the same edge.
- R8: half_n goes to 0 on the write that takes the count from DEPTH/2 to DEPTH/2+1. It returns to 1 on the read that takes the count back to DEPTH/2 or below.
- R9: A sampled low on rewind_n, with wr_n and rd_n both high, moves the read side to the first word written since reset. The count becomes the number of words written since reset, and empty_n, full_n and half_n follow that count. This requires that fewer than DEPTH words have been written since reset.
- R10: A low on rewind_n is ignored in any cycle where wr_n or rd_n is low.
- R11: dvalid is 1 only in the cycle after an accepted read, and 0 at every other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| rewind_n | input | 1 | Active-low request to replay from the first stored word |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Registered read data |
| dvalid | output | 1 | High in the cycle that dout holds a freshly read word |
| empty_n | output | 1 | Low when no words are stored |
| full_n | output | 1 | Low when DEPTH words are stored |
| half_n | output | 1 | Low when more than DEPTH/2 words are stored |

## Verification
The assertions assume that a rewind is only requested while fewer than DEPTH words have been written since the last reset. Without that, the write position has wrapped and the written-since-reset count is lost. The bench respects this: it applies reset before each directed group, and it issues rewinds only inside a group that writes 300 words into a 512-word store. The random phase starts from a fresh reset and never drives rewind_n low, so wrap-around of both positions is exercised freely there.

// File: rtl/retx_fifo_pkg.sv
package retx_fifo_pkg;
  // Accepted operations for one cycle, as decided by the control logic
  typedef struct packed {
    logic wr;
    logic rd;
    logic rewind;
  } fifo_op_t;
endpackage

// File: rtl/retx_fifo_rstsync.sv
module retx_fifo_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/retx_fifo_ctrl.sv
module retx_fifo_ctrl
  import retx_fifo_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          rewind_n,
  output fifo_op_t      op,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          empty_n,
  output logic          full_n,
  output logic          half_n
);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          half_q, half_d;
  logic          wr_ok, rd_ok, rw_ok;

  // next-state logic
  always_comb begin
    wr_ok = !wr_n && (cnt_q != FULL_CNT);
    rd_ok = !rd_n && (cnt_q != '0);
    rw_ok = !rewind_n && wr_n && rd_n;

    wr_ptr_d = wr_ptr_q;
    if (wr_ok) wr_ptr_d = wr_ptr_q + 1'b1;

    rd_ptr_d = rd_ptr_q;
    if (rw_ok)      rd_ptr_d = '0;
    else if (rd_ok) rd_ptr_d = rd_ptr_q + 1'b1;

    cnt_d = cnt_q;
    if (rw_ok) begin
      cnt_d = {1'b0, wr_ptr_q};
    end else begin
      unique case ({wr_ok, rd_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end

    half_d = (cnt_d > HALF_CNT);
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      half_q   <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      half_q   <= half_d;
    end
  end

  assign op      = '{wr: wr_ok, rd: rd_ok, rewind: rw_ok};
  assign wr_addr = wr_ptr_q;
  assign rd_addr = rd_ptr_q;
  assign empty_n = (cnt_q != '0);
  assign full_n  = (cnt_q != FULL_CNT);
  assign half_n  = !half_q;

  // R3
  no_wr_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && !wr_n) |=> $stable(wr_ptr_q));

  // R4
  no_rd_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && !rd_n) |=> $stable(rd_ptr_q));

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  // R9
  rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rewind_n && wr_n && rd_n) |=> (rd_ptr_q == '0) && $stable(wr_ptr_q));

  // R10
  rewind_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rewind_n && !rd_n && empty_n) |=> (rd_ptr_q == $past(rd_ptr_q) + 1'b1));

  // R8
  half_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !half_n |-> (cnt_q > HALF_CNT));
endmodule

// File: rtl/retx_fifo_ram.sv
module retx_fifo_ram
  import retx_fifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 512,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fifo_op_t          op,
  input  logic [AW-1:0]     wr_addr,
  input  logic [AW-1:0]     rd_addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dvalid
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] dout_q;
  logic              vld_q;

  always_ff @(posedge clk) begin
    if (op.wr) mem[wr_addr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= op.rd;
      if (op.rd) dout_q <= mem[rd_addr];
    end
  end

  assign dout   = dout_q;
  assign dvalid = vld_q;

  // R7
  no_addr_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op.wr && op.rd) |-> (wr_addr != rd_addr));
endmodule

// File: rtl/retx_fifo.sv
module retx_fifo
  import retx_fifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              rewind_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dvalid,
  output logic              empty_n,
  output logic              full_n,
  output logic              half_n
);
  localparam int AW = $clog2(DEPTH);

  logic          rst_s_n;
  fifo_op_t      op;
  logic [AW-1:0] wr_addr, rd_addr;

  retx_fifo_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  retx_fifo_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .wr_n     (wr_n),
    .rd_n     (rd_n),
    .rewind_n (rewind_n),
    .op       (op),
    .wr_addr  (wr_addr),
    .rd_addr  (rd_addr),
    .empty_n  (empty_n),
    .full_n   (full_n),
    .half_n   (half_n)
  );

  retx_fifo_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .op      (op),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .din     (din),
    .dout    (dout),
    .dvalid  (dvalid)
  );

  // R11
  dvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    dvalid |-> $past(!rd_n && empty_n));
endmodule

// File: tb/retx_fifo_tb.sv
module retx_fifo_tb_top;
  localparam int DW    = 9;
  localparam int DEPTH = 512;
  localparam int HALF  = DEPTH / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_n = 1'b1, rd_n = 1'b1, rewind_n = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dvalid, empty_n, full_n, half_n;

  int total = 0;
  int bad   = 0;

  logic [DW-1:0] hist [$];
  int            rd_idx = 0;

  always #2 clk = ~clk;

  retx_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rewind_n(rewind_n),
    .din(din), .dout(dout), .dvalid(dvalid),
    .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
  );

  function automatic int stored();
    return hist.size() - rd_idx;
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic chk_flags(input string tag);
    int c = stored();
    chk(empty_n === (c != 0), {tag, " R6 empty_n"}, int'(empty_n), int'(c != 0));
    chk(full_n === (c != DEPTH), {tag, " R5 full_n"}, int'(full_n), int'(c != DEPTH));
    chk(half_n === !(c > HALF), {tag, " R8 half_n"}, int'(half_n), int'(!(c > HALF)));
  endtask

  // one clock cycle: drive at negedge, update model at posedge, check at next negedge
  task automatic cyc(input bit w_n, input bit r_n, input bit t_n,
                     input logic [DW-1:0] d, input string tag);
    int c = stored();
    bit ra = !r_n && (c > 0);
    bit wa = !w_n && (c < DEPTH);
    bit rt = !t_n && w_n && r_n;
    logic [DW-1:0] ed = '0;
    if (ra) ed = hist[rd_idx];
    wr_n = w_n; rd_n = r_n; rewind_n = t_n; din = d;
    @(posedge clk);
    if (rt) rd_idx = 0;
    if (wa) hist.push_back(d);
    if (ra) rd_idx++;
    @(negedge clk);
    wr_n = 1'b1; rd_n = 1'b1; rewind_n = 1'b1;
    chk(dvalid === ra, {tag, " R11 dvalid"}, int'(dvalid), int'(ra));
    if (ra) chk(dout === ed, {tag, " R2 dout"}, int'(dout), int'(ed));
    chk_flags(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rewind_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(empty_n === 1'b0 && full_n === 1'b1 && half_n === 1'b1 && dvalid === 1'b0,
        "R1 flags in reset", int'({empty_n, full_n, half_n, dvalid}), 4'b0110);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    hist.delete();
    rd_idx = 0;
    // R1 after release
    chk(empty_n === 1'b0 && full_n === 1'b1 && half_n === 1'b1 && dvalid === 1'b0,
        "R1 flags after reset", int'({empty_n, full_n, half_n, dvalid}), 4'b0110);
  endtask

  function automatic logic [DW-1:0] rnd();
    return DW'($urandom_range(0, (1 << DW) - 1));
  endfunction

  initial begin
    #(4 * 400000);
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();

    // R4: read strobe at empty store
    cyc(1, 0, 1, rnd(), "R4 empty read");
    // R7: read and write at empty store, read must not see the write
    cyc(0, 0, 1, 9'h1A5, "R7 empty rw");
    cyc(1, 0, 1, '0, "R7 read back");

    // R5/R3: fill to full, then write while full
    do_reset();
    for (int i = 0; i < DEPTH; i++) cyc(0, 1, 1, rnd(), "R5 fill");
    cyc(0, 1, 1, 9'h0FF, "R3 write when full");
    cyc(0, 0, 1, 9'h0EE, "R3 rw when full");
    // drain; R2 order, R8 clear on the way down
    while (stored() > 0) cyc(1, 0, 1, '0, "R2 drain");
    cyc(1, 0, 1, '0, "R4 read after drain");

    // R8 thresholds
    do_reset();
    for (int i = 0; i < HALF; i++) cyc(0, 1, 1, rnd(), "R8 to half");
    cyc(0, 1, 1, rnd(), "R8 set");
    cyc(0, 0, 1, rnd(), "R7 rw at half+1");
    cyc(1, 0, 1, '0, "R8 clear");
    cyc(0, 1, 1, rnd(), "R8 set again");

    // R9/R10: rewind replay
    do_reset();
    for (int i = 0; i < 300; i++) cyc(0, 1, 1, rnd(), "R9 load");
    while (stored() > 0) cyc(1, 0, 1, '0, "R9 first pass");
    cyc(1, 1, 0, '0, "R9 rewind");
    for (int i = 0; i < 100; i++) cyc(1, 0, 1, '0, "R9 replay");
    cyc(1, 0, 0, '0, "R10 rewind with read");
    cyc(0, 1, 0, rnd(), "R10 rewind with write");
    cyc(1, 0, 1, '0, "R10 next word");
    cyc(1, 1, 0, '0, "R9 rewind again");
    while (stored() > 0) cyc(1, 0, 1, '0, "R9 second replay");

    // random traffic with wrap-around, no rewind
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      bit w = ($urandom_range(0, 99) < 55);
      bit r = ($urandom_range(0, 99) < 45);
      cyc(!w, !r, 1, rnd(), "R2 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule